// File: doc/BRIEF.md
# Block-Grid Luma Detail Shaper

This block works on a horizontal stream of 8-bit luma samples. Each sample is held on the input for two clocks, so one pixel takes two valid clocks. A three-tap low-pass filter runs over the stream. The detail signal is the current sample minus that low-pass value. Detail of small amplitude is treated as noise, and detail of large amplitude is treated as real picture content.

In denoise mode, the block subtracts a gain-scaled share of any detail whose magnitude is under a programmable threshold. In sharpen mode, it adds a gain-scaled share of any detail whose magnitude is over the threshold. The line is cut into square blocks of 8 or 16 pixels. The first and last pixel of each block use a separate edge gain. A 4-bit offset slides the grid by whole pixels, so the edge positions can be lined up with the source's block structure even when the input timing varies. The result is clamped to the 8-bit range and comes out one clock after the pixel is taken in.

Top module: `luma_block_nr`

## Requirements
- R1: While reset is high and on the first clock after it, `out_valid` is 0 and `out_luma` is 0.
- R2: After a line start, `in_valid` clocks are counted in pairs. The first clock of each pair takes in the pixel on `in_luma`. `out_valid` goes high for exactly one clock on the clock after that, with the result. `out_valid` is never high on two clocks in a row.
- R3: A clock with `line_start` high clears the pair phase, the pixel index and the filter history. Any `in_valid` on that clock is ignored and gives no output.
- R4: Detail is d = x - floor((p2 + 2*p1 + x)/4), where p1 and p2 are the two previous pixels of the line. The first pixel of a line uses itself for both p1 and p2, so its d is 0. The second pixel uses the first pixel for both p1 and p2.
- R5: With `cfg_mode` = 0 (denoise), if |d| < `cfg_thresh` the result is x - floor(g*d/16). Otherwise the result is x.
- R6: With `cfg_mode` = 1 (sharpen), if |d| > `cfg_thresh` the result is x + floor(g*d/16). Otherwise the result is x. A magnitude equal to the threshold leaves x unchanged in both modes.
- R7: The result is clamped to 0..255.
- R8: `cfg_blk16` = 1 selects 16-pixel blocks and 0 selects 8-pixel blocks. The k-th pixel after a line start (k from 0) has grid position ((k - `cfg_offset`) mod 16) mod size, with `cfg_offset` from 0 to 15.
- R9: The gain g is `cfg_border_gain`/16 at grid positions 0 and size-1, and `cfg_data_gain`/16 at every other position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start-of-line strobe; restarts phase, index and history |
| in_valid | input | 1 | Input sample valid; each pixel is held for two valid clocks |
| in_luma | input | 8 | Input luma sample |
| cfg_blk16 | input | 1 | Block width: 1 = 16 pixels, 0 = 8 pixels |
| cfg_offset | input | 4 | Grid shift in pixels |
| cfg_mode | input | 1 | 0 = denoise, 1 = sharpen |
| cfg_thresh | input | 8 | Detail magnitude threshold |
| cfg_data_gain | input | 4 | Gain for interior pixels, in sixteenths |
| cfg_border_gain | input | 4 | Gain for block-edge pixels, in sixteenths |
| out_valid | output | 1 | Result strobe, one clock per pixel |
| out_luma | output | 8 | Processed luma |

## Verification
If the pair phase is wrong, outputs appear on the wrong clock or twice per pixel. This shows on `out_valid` within the first pixel after a line start. If the pixel index or grid offset is off, the edge gain lands on the wrong pixels, and the output drifts from the expected value at the first pixel whose position crosses a block edge. If filter history is kept across a line start, the first pixel of the new line comes out with a nonzero correction. The bench walks tables of pixels under several mode, size and offset settings, and also probes threshold equality and clamping in both directions.

// File: rtl/luma_nr_pkg.sv
package luma_nr_pkg;

    localparam int PIX_W  = 8;
    localparam int GAIN_W = 4;
    localparam int OFF_W  = 4;
    localparam int IDX_W  = OFF_W;
    localparam int DET_W  = PIX_W + 2;
    localparam int PROD_W = DET_W + GAIN_W + 1;
    localparam int SUM_W  = PROD_W + 1;

    localparam logic [IDX_W-1:0] MASK_NARROW = IDX_W'((1 << (IDX_W - 1)) - 1);
    localparam logic [IDX_W-1:0] MASK_WIDE   = IDX_W'((1 << IDX_W) - 1);
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << PIX_W) - 1);

    typedef enum logic {
        MODE_DENOISE = 1'b0,
        MODE_SHARPEN = 1'b1
    } nr_mode_e;

    typedef struct packed {
        logic              blk16;
        logic [OFF_W-1:0]  offset;
        nr_mode_e          mode;
        logic [PIX_W-1:0]  thresh;
        logic [GAIN_W-1:0] data_gain;
        logic [GAIN_W-1:0] border_gain;
    } nr_cfg_t;

    typedef struct packed {
        logic [PIX_W-1:0]        x;
        logic signed [DET_W-1:0] detail;
        logic                    border;
    } nr_pix_t;

    function automatic logic [PIX_W-1:0] f_lowpass(
        input logic [PIX_W-1:0] a,
        input logic [PIX_W-1:0] b,
        input logic [PIX_W-1:0] c
    );
        logic [PIX_W+1:0] s;
        s = {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c};
        return s[PIX_W+1:2];
    endfunction

    function automatic logic signed [DET_W-1:0] f_detail(
        input logic [PIX_W-1:0] x,
        input logic [PIX_W-1:0] lp
    );
        return $signed({2'b00, x}) - $signed({2'b00, lp});
    endfunction

    function automatic logic [DET_W-1:0] f_mag(input logic signed [DET_W-1:0] d);
        logic signed [DET_W-1:0] n;
        n = -d;
        return d[DET_W-1] ? n : d;
    endfunction

    function automatic logic [PIX_W-1:0] f_clamp(input logic signed [SUM_W-1:0] s);
        if (s < 0)
            return '0;
        else if (s > SAT_HI)
            return '1;
        else
            return s[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/luma_nr_pace.sv
module luma_nr_pace
    import luma_nr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             in_valid,
    input  logic             blk16,
    input  logic [OFF_W-1:0] offset,
    output logic             accept,
    output logic [IDX_W-1:0] pix_idx,
    output logic             border
);

    logic             phase;
    logic [IDX_W-1:0] grid_pos;
    logic [IDX_W-1:0] grid_mask;

    // Two valid clocks per pixel; index steps after the second one.
    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            phase   <= 1'b0;
            pix_idx <= '0;
        end else if (in_valid) begin
            phase <= ~phase;
            if (phase)
                pix_idx <= pix_idx + 1'b1;
        end
    end

    assign accept    = in_valid && !line_start && !phase;
    assign grid_mask = blk16 ? MASK_WIDE : MASK_NARROW;

    always_comb begin
        grid_pos = (pix_idx - offset) & grid_mask;
        border   = (grid_pos == '0) || (grid_pos == grid_mask);
    end

endmodule

// File: rtl/luma_nr_hist.sv
module luma_nr_hist
    import luma_nr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    line_start,
    input  logic                    accept,
    input  logic [PIX_W-1:0]        x,
    output logic signed [DET_W-1:0] detail
);

    logic [PIX_W-1:0] prev1;
    logic [PIX_W-1:0] prev2;
    logic             first;
    logic [PIX_W-1:0] tap_a;
    logic [PIX_W-1:0] tap_b;
    logic [PIX_W-1:0] smooth;

    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            first <= 1'b1;
            prev1 <= '0;
            prev2 <= '0;
        end else if (accept) begin
            first <= 1'b0;
            prev1 <= x;
            prev2 <= first ? x : prev1;
        end
    end

    // Edge replication at the start of a line.
    always_comb begin
        tap_a  = first ? x : prev2;
        tap_b  = first ? x : prev1;
        smooth = f_lowpass(tap_a, tap_b, x);
        detail = f_detail(x, smooth);
    end

endmodule

// File: rtl/luma_nr_shape.sv
module luma_nr_shape
    import luma_nr_pkg::*;
(
    input  nr_pix_t          pix,
    input  nr_cfg_t          cfg,
    output logic [PIX_W-1:0] y
);

    logic [GAIN_W-1:0]        gain;
    logic [DET_W-1:0]         mag;
    logic                     apply;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] corr;
    logic signed [SUM_W-1:0]  base;
    logic signed [SUM_W-1:0]  corr_ext;
    logic signed [SUM_W-1:0]  total;

    always_comb begin
        gain = pix.border ? cfg.border_gain : cfg.data_gain;
        mag  = f_mag(pix.detail);

        unique case (cfg.mode)
            MODE_DENOISE: apply = mag < {2'b00, cfg.thresh};
            MODE_SHARPEN: apply = mag > {2'b00, cfg.thresh};
            default:      apply = 1'b0;
        endcase

        prod     = $signed({1'b0, gain}) * pix.detail;
        corr     = prod >>> GAIN_W;
        base     = $signed({{(SUM_W-PIX_W){1'b0}}, pix.x});
        corr_ext = {{(SUM_W-PROD_W){corr[PROD_W-1]}}, corr};

        if (!apply)
            total = base;
        else if (cfg.mode == MODE_SHARPEN)
            total = base + corr_ext;
        else
            total = base - corr_ext;

        y = f_clamp(total);
    end

endmodule

// File: rtl/luma_block_nr.sv
module luma_block_nr
    import luma_nr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_luma,
    input  logic              cfg_blk16,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic              cfg_mode,
    input  logic [PIX_W-1:0]  cfg_thresh,
    input  logic [GAIN_W-1:0] cfg_data_gain,
    input  logic [GAIN_W-1:0] cfg_border_gain,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_luma
);

    nr_cfg_t                 cfg;
    nr_pix_t                 pix;
    logic                    accept;
    logic [IDX_W-1:0]        pix_idx;
    logic                    border;
    logic signed [DET_W-1:0] detail;
    logic [PIX_W-1:0]        shaped;

    always_comb begin
        cfg.blk16       = cfg_blk16;
        cfg.offset      = cfg_offset;
        cfg.mode        = nr_mode_e'(cfg_mode);
        cfg.thresh      = cfg_thresh;
        cfg.data_gain   = cfg_data_gain;
        cfg.border_gain = cfg_border_gain;
    end

    luma_nr_pace u_pace (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .in_valid   (in_valid),
        .blk16      (cfg.blk16),
        .offset     (cfg.offset),
        .accept     (accept),
        .pix_idx    (pix_idx),
        .border     (border)
    );

    luma_nr_hist u_hist (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .accept     (accept),
        .x          (in_luma),
        .detail     (detail)
    );

    always_comb begin
        pix.x      = in_luma;
        pix.detail = detail;
        pix.border = border;
    end

    luma_nr_shape u_shape (
        .pix (pix),
        .cfg (cfg),
        .y   (shaped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_luma  <= '0;
        end else begin
            out_valid <= accept;
            if (accept)
                out_luma <= shaped;
        end
    end

endmodule

// File: rtl/luma_nr_chk.sv
module luma_nr_chk
    import luma_nr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             line_start,
    input logic             in_valid,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_luma,
    input logic [IDX_W-1:0] pix_idx
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!out_valid && out_luma == '0));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2
    accept_source_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && !line_start));

    // R3
    line_restart_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (pix_idx == '0 && !out_valid));

    // R8
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !line_start) |=> $stable(pix_idx));

endmodule

bind luma_block_nr luma_nr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_luma   (out_luma),
    .pix_idx    (pix_idx)
);

// File: tb/luma_block_nr_bench.sv
module luma_block_nr_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       line_start;
    logic       in_valid;
    logic [7:0] in_luma;
    logic       cfg_blk16;
    logic [3:0] cfg_offset;
    logic       cfg_mode;
    logic [7:0] cfg_thresh;
    logic [3:0] cfg_data_gain;
    logic [3:0] cfg_border_gain;
    logic       out_valid;
    logic [7:0] out_luma;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int m_p1, m_p2, m_k;
    bit m_first;

    localparam int NTAB = 24;
    localparam logic [7:0] PIX_TAB [0:NTAB-1] = '{
        8'd16,  8'd20,  8'd18,  8'd60,  8'd200, 8'd190, 8'd185, 8'd30,
        8'd32,  8'd35,  8'd240, 8'd10,  8'd12,  8'd128, 8'd130, 8'd126,
        8'd90,  8'd255, 8'd0,   8'd5,   8'd70,  8'd72,  8'd150, 8'd149
    };

    localparam int NPASS = 4;
    localparam logic       P_BLK  [0:NPASS-1] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [3:0] P_OFF  [0:NPASS-1] = '{4'd0, 4'd5, 4'd10, 4'd15};
    localparam logic       P_MODE [0:NPASS-1] = '{1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [7:0] P_TH   [0:NPASS-1] = '{8'd40, 8'd25, 8'd20, 8'd8};

    luma_block_nr u_luma_block_nr (
        .clk             (clk),
        .rst             (rst),
        .line_start      (line_start),
        .in_valid        (in_valid),
        .in_luma         (in_luma),
        .cfg_blk16       (cfg_blk16),
        .cfg_offset      (cfg_offset),
        .cfg_mode        (cfg_mode),
        .cfg_thresh      (cfg_thresh),
        .cfg_data_gain   (cfg_data_gain),
        .cfg_border_gain (cfg_border_gain),
        .out_valid       (out_valid),
        .out_luma        (out_luma)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic new_line();
        @(negedge clk);
        line_start = 1'b1;
        in_valid   = 1'b0;
        @(negedge clk);
        line_start = 1'b0;
        m_first = 1'b1;
        m_k     = 0;
    endtask

    task automatic go_idle();
        @(negedge clk);
        check(out_valid == 1'b0, "R2 no second pulse", int'(out_valid), 0);
        in_valid = 1'b0;
    endtask

    task automatic send_chk(input logic [7:0] x, input int exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_luma  = x;
        @(negedge clk);
        check(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
        check(int'(out_luma) == exp, tag, int'(out_luma), exp);
    endtask

    task automatic send_model(input logic [7:0] x, input string tag);
        int p1, p2, lp, d, mag, mask, pos, g, corr, y;
        if (m_first) begin
            p1 = int'(x);
            p2 = int'(x);
        end else begin
            p1 = m_p1;
            p2 = m_p2;
        end
        lp   = (p2 + 2 * p1 + int'(x)) / 4;
        d    = int'(x) - lp;
        mag  = (d < 0) ? -d : d;
        mask = cfg_blk16 ? 15 : 7;
        pos  = (((m_k - int'(cfg_offset)) + 16) % 16) & mask;
        g    = (pos == 0 || pos == mask) ? int'(cfg_border_gain) : int'(cfg_data_gain);
        corr = (g * d) >>> 4;
        y    = int'(x);
        if (!cfg_mode && mag < int'(cfg_thresh)) y = int'(x) - corr;
        if (cfg_mode && mag > int'(cfg_thresh))  y = int'(x) + corr;
        if (y < 0)   y = 0;
        if (y > 255) y = 255;
        m_p2    = m_first ? int'(x) : m_p1;
        m_p1    = int'(x);
        m_first = 1'b0;
        m_k     = (m_k + 1) % 16;
        send_chk(x, y, tag);
    endtask

    task automatic set_cfg(input logic blk, input logic [3:0] off, input logic mode,
                           input logic [7:0] th, input logic [3:0] dg, input logic [3:0] bg);
        @(negedge clk);
        cfg_blk16       = blk;
        cfg_offset      = off;
        cfg_mode        = mode;
        cfg_thresh      = th;
        cfg_data_gain   = dg;
        cfg_border_gain = bg;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        line_start = 1'b0;
        in_valid = 1'b0;
        in_luma = '0;
        cfg_blk16 = 1'b0;
        cfg_offset = '0;
        cfg_mode = 1'b0;
        cfg_thresh = '0;
        cfg_data_gain = '0;
        cfg_border_gain = '0;
        m_first = 1'b1;
        m_k = 0;
        m_p1 = 0;
        m_p2 = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_luma == 8'd0, "R1 luma in reset", int'(out_luma), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_luma == 8'd0, "R1 after reset", int'(out_luma), 0);

        // Table walk across mode, block size and offset (R4 R5 R6 R8 R9)
        for (int p = 0; p < NPASS; p++) begin
            set_cfg(P_BLK[p], P_OFF[p], P_MODE[p], P_TH[p], 4'd12, 4'd4);
            new_line();
            for (int i = 0; i < NTAB; i++)
                send_model(PIX_TAB[i], P_MODE[p] ? "R6 R8 R9 table" : "R5 R8 R9 table");
            go_idle();
        end

        // R3: valid during line start is ignored, history and phase cleared
        set_cfg(1'b0, 4'd0, 1'b1, 8'd0, 4'd15, 4'd15);
        @(negedge clk);
        line_start = 1'b1;
        in_valid   = 1'b1;
        in_luma    = 8'd99;
        @(negedge clk);
        check(out_valid == 1'b0, "R3 valid with line start ignored", int'(out_valid), 0);
        line_start = 1'b0;
        in_valid   = 1'b0;
        m_first = 1'b1;
        m_k     = 0;
        // R4: first pixel of a line has zero detail
        send_chk(8'd200, 200, "R3 R4 first pixel unchanged");
        go_idle();

        // R7: clamp high and low in sharpen mode with full gain
        new_line();
        send_chk(8'd0, 0, "R7 lead");
        send_chk(8'd0, 0, "R7 lead");
        send_chk(8'd255, 255, "R7 clamp high");
        go_idle();
        new_line();
        send_chk(8'd255, 255, "R7 lead");
        send_chk(8'd255, 255, "R7 lead");
        send_chk(8'd0, 0, "R7 clamp low");
        go_idle();

        // Threshold equality and one step past it; pattern 0,0,64 gives d=48 at k=2
        set_cfg(1'b0, 4'd0, 1'b0, 8'd48, 4'd8, 4'd4);
        new_line(); send_chk(8'd0, 0, "R5 lead"); send_chk(8'd0, 0, "R5 lead");
        send_chk(8'd64, 64, "R5 equal threshold no change"); go_idle();
        set_cfg(1'b0, 4'd0, 1'b0, 8'd49, 4'd8, 4'd4);
        new_line(); send_chk(8'd0, 0, "R5 lead"); send_chk(8'd0, 0, "R5 lead");
        send_chk(8'd64, 40, "R5 below threshold subtract"); go_idle();
        set_cfg(1'b0, 4'd0, 1'b1, 8'd48, 4'd8, 4'd4);
        new_line(); send_chk(8'd0, 0, "R6 lead"); send_chk(8'd0, 0, "R6 lead");
        send_chk(8'd64, 64, "R6 equal threshold no change"); go_idle();
        set_cfg(1'b0, 4'd0, 1'b1, 8'd47, 4'd8, 4'd4);
        new_line(); send_chk(8'd0, 0, "R6 lead"); send_chk(8'd0, 0, "R6 lead");
        send_chk(8'd64, 88, "R6 above threshold add"); go_idle();

        // R8 R9: grid offset moves the edge gain onto pixel k=2
        set_cfg(1'b0, 4'd3, 1'b1, 8'd0, 4'd8, 4'd4);
        new_line(); send_chk(8'd0, 0, "R9 lead"); send_chk(8'd0, 0, "R9 lead");
        send_chk(8'd64, 76, "R8 R9 size8 offset3 last position"); go_idle();
        set_cfg(1'b0, 4'd2, 1'b1, 8'd0, 4'd8, 4'd4);
        new_line(); send_chk(8'd0, 0, "R9 lead"); send_chk(8'd0, 0, "R9 lead");
        send_chk(8'd64, 76, "R8 R9 size8 offset2 position zero"); go_idle();
        set_cfg(1'b1, 4'd3, 1'b1, 8'd0, 4'd8, 4'd4);
        new_line(); send_chk(8'd0, 0, "R9 lead"); send_chk(8'd0, 0, "R9 lead");
        send_chk(8'd64, 76, "R8 R9 size16 offset3 last position"); go_idle();
        set_cfg(1'b1, 4'd11, 1'b1, 8'd0, 4'd8, 4'd4);
        new_line(); send_chk(8'd0, 0, "R9 lead"); send_chk(8'd0, 0, "R9 lead");
        send_chk(8'd64, 88, "R8 R9 size16 offset11 interior"); go_idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule